// File: doc/BRIEF.md
# DRAM Start-up and Refresh Scheduler

This block brings a fast page mode DRAM out of power-up and keeps it refreshed. After reset it keeps every strobe inactive for a power-up pause of at least a configured number of microseconds. It then runs a fixed number of warm-up refresh cycles back to back on its own. Once the last of these has finished it raises a ready flag. From then on it schedules refreshes in which CAS falls before RAS, so the memory's internal row counter supplies the row.

In normal operation an interval timer adds one owed refresh to a small saturating counter every refresh interval. While refreshes are owed and no cycle is running, the block raises a request to the access controller. When the controller grants while the request is high, the block takes the RAS, CAS and WE lines for one complete refresh cycle and signals this ownership on a strobe-enable output. Each grant serves exactly one owed refresh. A grant that arrives late therefore loses nothing, up to the counter limit.

All strobe timings are given in nanoseconds and converted to clock cycles by rounding up, using the clock frequency parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and at any time `strobe_oe` is low, `ras_n` and `cas_n` are high. During reset, `we_n` is high and `strobe_oe`, `ref_req` and `init_done` are low.
- R2: After reset is released, `strobe_oe` stays low for at least PAUSE_US x CLK_MHZ clock cycles, and it rises within a few cycles after that.
- R3: After the pause, exactly WARMUP_CYCLES refresh cycles run without `ref_req` ever being raised. `init_done` rises after the last of them ends and stays high until reset.
- R4: In every refresh cycle CAS falls first. It is low for ceil(CSR_NS) cycles with RAS high, stays low for ceil(CHR_NS) cycles after RAS falls, and then returns high while RAS is still low.
- R5: `we_n` is high in every cycle in which `strobe_oe` is high.
- R6: RAS is held low for ceil(RAS_NS) cycles. After RAS rises, all strobes stay high for max(ceil(RP_NS), ceil(RC_NS) - ceil(RAS_NS) - ceil(CSR_NS)) cycles before `strobe_oe` drops.
- R7: After `init_done` rises, one refresh becomes owed every ceil(INTERVAL_NS) cycles. With the grant held high, successive RAS falls are exactly that many cycles apart, and the first comes about one interval after `init_done` rises.
- R8: `ref_req` is high exactly when at least one refresh is owed, `init_done` is high and no refresh cycle is running. Each grant sampled while `ref_req` is high starts one cycle and pays off one owed refresh. With nothing owed, `ref_req` is low.
- R9: The owed-refresh count saturates at PEND_MAX. After the grant is withheld for more than PEND_MAX intervals, exactly PEND_MAX cycles run once the grant returns.
- R10: Refreshes that become owed while the grant is withheld are kept. After three intervals without a grant, exactly three cycles run back to back once it returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request to the access controller |
| strobe_oe | output | 1 | High while this block owns RAS, CAS and WE |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| init_done | output | 1 | Pause and warm-up complete |

## Verification
The bench keeps the clock at 250 MHz and the strobe timings at their default nanosecond values, so the expected profile of each cycle is 2, 15, 3 and 11 cycles. It shortens PAUSE_US to 1 (250 cycles) and INTERVAL_NS to 2400 (600 cycles). With these values the pause, the warm-up, a run of more than PEND_MAX withheld intervals, and a three-interval late grant all fit within a few tens of thousands of cycles. Each burst of eight refresh cycles also completes well before the next tick of the interval timer.

// File: rtl/drfs_pkg.sv
package drfs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CSR,
    SEQ_RASLO,
    SEQ_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_PAUSE,
    MODE_WARM,
    MODE_RUN
  } mode_e;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Precharge length that satisfies both the precharge and the full-cycle minimum.
  function automatic int unsigned pre_len(input int unsigned rp_c,
                                          input int unsigned rc_c,
                                          input int unsigned ras_c,
                                          input int unsigned csr_c);
    int unsigned used;
    used = ras_c + csr_c;
    return (rc_c > used) ? max2(rp_c, rc_c - used) : rp_c;
  endfunction

endpackage

// File: rtl/drfs_cycle_timer.sv
module drfs_cycle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drfs_cbr_seq.sv
module drfs_cbr_seq
  import drfs_pkg::*;
#(
  parameter int unsigned T_CSR = 2,
  parameter int unsigned T_CHR = 3,
  parameter int unsigned T_RAS = 15,
  parameter int unsigned T_PRE = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned LMAX = max2(max2(T_CSR, T_RAS), T_PRE);
  localparam int unsigned CW = $clog2(LMAX + 1);

  seq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            phase_end;

  always_comb begin
    case (state_q)
      SEQ_CSR:   phase_end = (cnt_q == CW'(T_CSR - 1));
      SEQ_RASLO: phase_end = (cnt_q == CW'(T_RAS - 1));
      SEQ_PRE:   phase_end = (cnt_q == CW'(T_PRE - 1));
      default:   phase_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go) begin
          state_q <= SEQ_CSR;
          cnt_q   <= '0;
        end
        SEQ_CSR: if (phase_end) begin
          state_q <= SEQ_RASLO;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        SEQ_RASLO: if (phase_end) begin
          state_q <= SEQ_PRE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (phase_end) begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign busy  = (state_q != SEQ_IDLE);
  assign done  = (state_q == SEQ_PRE) && phase_end;
  assign ras_n = (state_q != SEQ_RASLO);
  assign cas_n = !((state_q == SEQ_CSR) ||
                   ((state_q == SEQ_RASLO) && (cnt_q < CW'(T_CHR))));
  assign we_n  = 1'b1;
endmodule

// File: rtl/drfs_pend_ctr.sv
module drfs_pend_ctr #(
  parameter int unsigned MAX = 8,
  parameter int unsigned W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         nonzero
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec && cnt != TOP) cnt <= cnt + 1'b1;
    else if (dec && !inc && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign nonzero = (cnt != '0);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drfs_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 250,
  parameter int unsigned PAUSE_US      = 200,
  parameter int unsigned INTERVAL_NS   = 15600,
  parameter int unsigned WARMUP_CYCLES = 8,
  parameter int unsigned PEND_MAX      = 8,
  parameter int unsigned CSR_NS        = 5,
  parameter int unsigned CHR_NS        = 10,
  parameter int unsigned RAS_NS        = 60,
  parameter int unsigned RP_NS         = 40,
  parameter int unsigned RC_NS         = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic strobe_oe,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int unsigned IVL_CYC   = ns_to_cyc(INTERVAL_NS, CLK_MHZ);
  localparam int unsigned C_CSR     = ns_to_cyc(CSR_NS, CLK_MHZ);
  localparam int unsigned C_CHR     = ns_to_cyc(CHR_NS, CLK_MHZ);
  localparam int unsigned C_RAS     = ns_to_cyc(RAS_NS, CLK_MHZ);
  localparam int unsigned C_PRE     = pre_len(ns_to_cyc(RP_NS, CLK_MHZ),
                                              ns_to_cyc(RC_NS, CLK_MHZ),
                                              C_RAS, C_CSR);
  localparam int unsigned PEND_W    = $clog2(PEND_MAX + 1);
  localparam int unsigned WARM_W    = $clog2(WARMUP_CYCLES + 1);

  mode_e              mode_q;
  logic [WARM_W-1:0]  warm_cnt_q;
  logic               pause_active, warm_active, run_active;
  logic               pause_tick, ivl_tick;
  logic               seq_go, seq_busy, seq_done;
  logic               refresh_taken, warm_last;
  logic [PEND_W-1:0]  pend_cnt;
  logic               pend_nz;

  assign pause_active = (mode_q == MODE_PAUSE);
  assign warm_active  = (mode_q == MODE_WARM);
  assign run_active   = (mode_q == MODE_RUN);

  drfs_cycle_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(pause_active), .tick(pause_tick)
  );

  drfs_cycle_timer #(.LIMIT(IVL_CYC)) u_ivl (
    .clk(clk), .rst_n(rst_n), .en(run_active), .tick(ivl_tick)
  );

  assign ref_req       = run_active && pend_nz && !seq_busy;
  assign refresh_taken = ref_req && ref_gnt;
  assign seq_go        = (warm_active && !seq_busy) || refresh_taken;
  assign warm_last     = warm_active && seq_done &&
                         (warm_cnt_q == WARM_W'(WARMUP_CYCLES - 1));

  drfs_pend_ctr #(.MAX(PEND_MAX), .W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(ivl_tick), .dec(refresh_taken),
    .cnt(pend_cnt), .nonzero(pend_nz)
  );

  drfs_cbr_seq #(.T_CSR(C_CSR), .T_CHR(C_CHR), .T_RAS(C_RAS), .T_PRE(C_PRE)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(seq_go), .busy(seq_busy), .done(seq_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_PAUSE;
      warm_cnt_q <= '0;
    end else begin
      case (mode_q)
        MODE_PAUSE: if (pause_tick) mode_q <= MODE_WARM;
        MODE_WARM: begin
          if (seq_done) warm_cnt_q <= warm_cnt_q + 1'b1;
          if (warm_last) mode_q <= MODE_RUN;
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  assign strobe_oe = seq_busy;
  assign init_done = run_active;
endmodule

// File: rtl/drfs_checks.sv
module drfs_checks #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          strobe_oe,
  input logic          ref_req,
  input logic          init_done,
  input logic          pause_active,
  input logic [PW-1:0] pend_cnt
);
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_oe |-> (ras_n && cas_n)); // R1
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> !strobe_oe); // R2
  AST_NO_REQ_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req); // R3
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R3
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4
  AST_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_oe |-> we_n); // R5
  AST_REQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (pend_cnt != '0 && !strobe_oe)); // R8
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PEND_MAX)); // R9
endmodule

bind dram_refresh_sched drfs_checks #(.PEND_MAX(PEND_MAX), .PW(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .strobe_oe(strobe_oe), .ref_req(ref_req), .init_done(init_done),
  .pause_active(pause_active), .pend_cnt(pend_cnt)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int PER_NS = 4;
  localparam int PAUSE  = 1 * 250;
  localparam int IVL    = 2400 / PER_NS;
  localparam int WARM   = 8;
  localparam int SAT    = 8;

  function automatic int up(input int ns);
    return (ns + PER_NS - 1) / PER_NS;
  endfunction

  typedef struct { int lead; int low; int caslow; int pre; } prof_t;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, strobe_oe, ras_n, cas_n, we_n, init_done;

  always #2 clk = ~clk;

  dram_refresh_sched #(.CLK_MHZ(250), .PAUSE_US(1), .INTERVAL_NS(2400),
                       .WARMUP_CYCLES(WARM), .PEND_MAX(SAT)) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .strobe_oe(strobe_oe), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .init_done(init_done)
  );

  int checks = 0, fails = 0, cyc = 0;
  int we_err = 0, req_early = 0, falls = 0;
  int fall_cyc[$];
  prof_t exp_q[$];
  prof_t exp_p;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic push_expected(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(exp_p);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: measures every refresh cycle and compares it with the scoreboard.
  int lead = 0, low = 0, caslow = 0, pre = 0;
  bit seen_ras = 0, prev_ras = 1, prev_oe = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (strobe_oe && !we_n) we_err++;
      if (!init_done && ref_req) req_early++;
      if (prev_ras && !ras_n) begin
        seen_ras = 1; falls++; fall_cyc.push_back(cyc);
      end
      if (strobe_oe) begin
        if (ras_n && !cas_n && !seen_ras) lead++;
        if (!ras_n) begin low++; if (!cas_n) caslow++; end
        if (ras_n && cas_n && seen_ras) pre++;
      end
      if (prev_oe && !strobe_oe) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected refresh cycle", falls, 0);
        else begin
          prof_t e;
          e = exp_q.pop_front();
          chk(lead == e.lead && caslow == e.caslow, "R4 cas lead/hold",
              lead * 100 + caslow, e.lead * 100 + e.caslow);
          chk(low == e.low && pre == e.pre, "R6 ras low/precharge",
              low * 100 + pre, e.low * 100 + e.pre);
        end
        lead = 0; low = 0; caslow = 0; pre = 0; seen_ras = 0;
      end
      prev_ras = ras_n;
      prev_oe  = strobe_oe;
    end
  end

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    int n, t0, f0;
    exp_p.lead   = up(5);
    exp_p.caslow = up(10);
    exp_p.low    = up(60);
    exp_p.pre    = (up(110) - up(60) - up(5) > up(40)) ? up(110) - up(60) - up(5) : up(40);

    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!strobe_oe && !ref_req && !init_done, "R1 outputs low in reset",
        {strobe_oe, ref_req, init_done}, 0);
    push_expected(WARM);
    rst_n = 1'b1;

    n = 0;
    while (!strobe_oe) begin @(negedge clk); n++; end
    chk(n >= PAUSE && n <= PAUSE + 4, "R2 pause length", n, PAUSE);

    while (!init_done) @(negedge clk);
    t0 = cyc;
    chk(falls == WARM, "R3 warm-up cycle count", falls, WARM);
    chk(req_early == 0, "R3 no request during warm-up", req_early, 0);
    chk(!strobe_oe, "R3 init after last cycle ends", strobe_oe, 0);

    // R7: grant held high, one refresh per interval.
    ref_gnt = 1'b1;
    push_expected(3);
    while (falls < WARM + 3) @(negedge clk);
    chk(fall_cyc[WARM] - t0 >= IVL && fall_cyc[WARM] - t0 <= IVL + 5,
        "R7 first refresh after init", fall_cyc[WARM] - t0, IVL);
    chk(fall_cyc[WARM+1] - fall_cyc[WARM] == IVL, "R7 spacing 1",
        fall_cyc[WARM+1] - fall_cyc[WARM], IVL);
    chk(fall_cyc[WARM+2] - fall_cyc[WARM+1] == IVL, "R7 spacing 2",
        fall_cyc[WARM+2] - fall_cyc[WARM+1], IVL);

    // R9: withhold for more than eight intervals.
    wait_until(t0 + 3 * IVL + IVL / 2);
    ref_gnt = 1'b0;
    chk(!ref_req, "R8 no request with nothing owed", ref_req, 0);
    wait_until(t0 + 12 * IVL + IVL / 2);
    chk(ref_req && !strobe_oe, "R8 request while owed", ref_req, 1);
    push_expected(SAT);
    f0 = falls;
    ref_gnt = 1'b1;
    repeat (240) @(negedge clk);
    chk(falls - f0 == SAT, "R9 saturated burst", falls - f0, SAT);
    chk(!ref_req, "R8 request drops when paid off", ref_req, 0);
    ref_gnt = 1'b0;

    // R10: three intervals without grant.
    wait_until(t0 + 15 * IVL + IVL / 2);
    push_expected(3);
    f0 = falls;
    ref_gnt = 1'b1;
    repeat (240) @(negedge clk);
    chk(falls - f0 == 3, "R10 late grant keeps owed refreshes", falls - f0, 3);
    ref_gnt = 1'b0;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected cycles seen", exp_q.size(), 0);
    chk(we_err == 0, "R5 we_n high while owning strobes", we_err, 0);
    chk(init_done, "R3 init_done stays high", init_done, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule